// File: doc/BRIEF.md
# Double-Fault Repairing Bank of Four-Point FFTs

The block runs four independent 4-point complex FFTs side by side and keeps their results correct even when soft errors corrupt the outputs of up to two of the four engines at the same time. Three extra FFT engines each transform the sum of the inputs of three original engines. Because the transform is linear, each extra spectrum equals the sum of the three original spectra it covers. Each of the three covered sets leaves out a different original engine. This lets a damaged spectrum be rebuilt by subtraction, using a covered set that contains no other damaged engine.

Each original engine has a detector built from adders only. When a pair of engines is flagged, the controller rebuilds first the engine that has a clean check equation. The rebuilt spectrum then feeds the repair of the second engine one pipeline stage later. A single flagged engine is rebuilt in the first repair stage. With three or four flagged engines the block reports the set as uncorrectable and passes the spectra on untouched.

Data moves in and out over valid/ready handshakes. The whole pipeline advances only when its output register is empty or is being drained. A stalled output therefore holds its data and lowers `in_ready`. For test, a soft error can be placed on the result of any original engine.

Top module: `fft_pair_corrector`

## Requirements
- R1: While reset is held and after it is released, `out_valid` is 0. Once reset is released and the output is empty, `in_ready` is 1.
- R2: With no injected error, output spectrum bin k of engine e equals the 4-point DFT of input vector e: X[k] = sum over n of x[n]·exp(-j2πkn/4). Index order is [engine][bin]. Also `out_fault` is 0 and `out_uncorr` is 0.
- R3: A vector accepted on a clock edge (`in_valid` and `in_ready` both high) appears on the output with `out_valid` high after the third edge. This latency is the same whether zero, one or two engines are repaired.
- R4: Injection works as follows. For each engine e with `inj_eng[e]` set, `inj_flip` is XORed into the real part of bin `inj_bin` of that engine's raw result. The error is taken together with the accepted vector. A nonzero flip sets `out_fault[e]` for exactly those engines.
- R5: When one engine is flagged, its output spectrum equals the fault-free DFT and `out_uncorr` is 0.
- R6: For every pair of flagged engines, both output spectra equal the fault-free DFT. The repair uses check set 0 = engines {0,1,2}, set 1 = {0,1,3} and set 2 = {0,2,3}. The first repair uses a set that excludes the second faulty engine. The second repair may use the first repaired result.
- R7: When three or four engines are flagged, `out_uncorr` is 1 and every output spectrum equals the raw (faulty) engine result.
- R8: While `out_valid` is 1 and `out_ready` is 0, the outputs stay unchanged, `out_valid` stays 1, `in_ready` is 0, and a vector offered then is not taken until the stall ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input vectors present |
| in_ready | output | 1 | Block can take a vector set |
| in_re | input | 4x4xSW | Real parts, [engine][sample] |
| in_im | input | 4x4xSW | Imaginary parts, [engine][sample] |
| inj_eng | input | 4 | Engines whose result gets the soft error |
| inj_bin | input | 2 | Bin that receives the error |
| inj_flip | input | SW+2 | XOR pattern applied to the real part |
| out_valid | output | 1 | Output spectra present |
| out_ready | input | 1 | Consumer takes the output |
| out_re | output | 4x4x(SW+2) | Corrected real parts, [engine][bin] |
| out_im | output | 4x4x(SW+2) | Corrected imaginary parts, [engine][bin] |
| out_fault | output | 4 | Engines flagged by their detectors |
| out_uncorr | output | 1 | Too many flagged engines to repair |

## Verification
The two functions that can coincide are an output stall and a two-step repair still in flight. The bench sends a vector with two damaged engines while `out_ready` is low, so the sequentially repaired result lands in the stalled output register. It then holds the stall for several cycles and offers a second damaged vector while `in_ready` is low. The held output must stay bit-for-bit equal to the fault-free spectra throughout the stall. After release, the second vector must come out repaired as well, exactly three edges after the edge that accepted it.

// File: rtl/fft_pc_pkg.sv
package fft_pc_pkg;
  localparam int NENG = 4;
  localparam int NRED = 3;

  typedef struct packed {
    logic       uncorr;
    logic       en1;
    logic [1:0] eng1;
    logic [1:0] eq1;
    logic       en2;
    logic [1:0] eng2;
    logic [1:0] eq2;
  } fix_plan_t;

  // engines covered by each check set
  function automatic logic [3:0] eq_members(input logic [1:0] q);
    case (q)
      2'd0:    return 4'b0111;
      2'd1:    return 4'b1011;
      2'd2:    return 4'b1101;
      default: return 4'b0000;
    endcase
  endfunction

  // first check set that holds engine inc and not engine exc (exc<0: none)
  function automatic int pick_eq(input int inc, input int exc);
    logic [3:0] m;
    for (int q = 0; q < NRED; q++) begin
      m = eq_members(2'(q));
      if (m[inc] && !(exc >= 0 && m[exc])) return q;
    end
    return -1;
  endfunction

  function automatic fix_plan_t plan_for(input logic [3:0] f);
    fix_plan_t p;
    int a, b, qa, qb, n;
    p = '0;
    a = -1;
    b = -1;
    n = 0;
    for (int i = 0; i < NENG; i++) begin
      if (f[i]) begin
        n++;
        if (a < 0) a = i;
        else b = i;
      end
    end
    if (n == 1) begin
      p.en1  = 1'b1;
      p.eng1 = 2'(a);
      p.eq1  = 2'(pick_eq(a, -1));
    end else if (n == 2) begin
      qa = pick_eq(a, b);
      qb = pick_eq(b, a);
      if (qa >= 0) begin
        p.en1 = 1'b1; p.eng1 = 2'(a); p.eq1 = 2'(qa);
        p.en2 = 1'b1; p.eng2 = 2'(b); p.eq2 = 2'(pick_eq(b, -1));
      end else if (qb >= 0) begin
        p.en1 = 1'b1; p.eng1 = 2'(b); p.eq1 = 2'(qb);
        p.en2 = 1'b1; p.eng2 = 2'(a); p.eq2 = 2'(pick_eq(a, -1));
      end else begin
        p.uncorr = 1'b1;
      end
    end else if (n > 2) begin
      p.uncorr = 1'b1;
    end
    return p;
  endfunction
endpackage

// File: rtl/fft4_core.sv
module fft4_core #(
  parameter int IW = 12,
  parameter int OW = IW + 2
) (
  input  logic [3:0][IW-1:0] xr,
  input  logic [3:0][IW-1:0] xi,
  output logic [3:0][OW-1:0] yr,
  output logic [3:0][OW-1:0] yi
);
  logic signed [OW-1:0] sr02, dr02, sr13, dr13, si02, di02, si13, di13;

  always_comb begin
    sr02 = OW'($signed(xr[0])) + OW'($signed(xr[2]));
    dr02 = OW'($signed(xr[0])) - OW'($signed(xr[2]));
    sr13 = OW'($signed(xr[1])) + OW'($signed(xr[3]));
    dr13 = OW'($signed(xr[1])) - OW'($signed(xr[3]));
    si02 = OW'($signed(xi[0])) + OW'($signed(xi[2]));
    di02 = OW'($signed(xi[0])) - OW'($signed(xi[2]));
    si13 = OW'($signed(xi[1])) + OW'($signed(xi[3]));
    di13 = OW'($signed(xi[1])) - OW'($signed(xi[3]));
    yr[0] = sr02 + sr13;  yi[0] = si02 + si13;
    yr[1] = dr02 + di13;  yi[1] = di02 - dr13;
    yr[2] = sr02 - sr13;  yi[2] = si02 - si13;
    yr[3] = dr02 - di13;  yi[3] = di02 + dr13;
  end
endmodule

// File: rtl/sum_checker.sv
module sum_checker #(
  parameter int SW = 12,
  parameter int OW = SW + 2
) (
  input  logic [3:0][SW-1:0] xr,
  input  logic [3:0][SW-1:0] xi,
  input  logic [3:0][OW-1:0] yr,
  input  logic [3:0][OW-1:0] yi,
  output logic               bad
);
  localparam int CW = OW + 2;
  logic signed [CW-1:0] tx_r, tx_i, ty_r, ty_i;

  always_comb begin
    tx_r = '0; tx_i = '0; ty_r = '0; ty_i = '0;
    for (int n = 0; n < 4; n++) begin
      tx_r += CW'($signed(xr[n]));
      tx_i += CW'($signed(xi[n]));
      ty_r += CW'($signed(yr[n]));
      ty_i += CW'($signed(yi[n]));
    end
    // DC bin against sample sum, bin sum against four times first sample
    bad = (tx_r != CW'($signed(yr[0]))) || (tx_i != CW'($signed(yi[0]))) ||
          (ty_r != (CW'($signed(xr[0])) <<< 2)) || (ty_i != (CW'($signed(xi[0])) <<< 2));
  end
endmodule

// File: rtl/repair_unit.sv
module repair_unit
  import fft_pc_pkg::*;
#(
  parameter int OW = 14,
  parameter int RW = OW + 2
) (
  input  logic                          en,
  input  logic [1:0]                    eng,
  input  logic [1:0]                    eq,
  input  logic [3:0][3:0][OW-1:0]       sp_re,
  input  logic [3:0][3:0][OW-1:0]       sp_im,
  input  logic [NRED-1:0][3:0][RW-1:0]  rd_re,
  input  logic [NRED-1:0][3:0][RW-1:0]  rd_im,
  output logic [3:0][3:0][OW-1:0]       fx_re,
  output logic [3:0][3:0][OW-1:0]       fx_im
);
  localparam int AW = RW + 2;
  logic [3:0] mem;
  logic signed [AW-1:0] acc_r, acc_i;

  always_comb begin
    fx_re = sp_re;
    fx_im = sp_im;
    mem   = eq_members(eq);
    acc_r = '0;
    acc_i = '0;
    if (en) begin
      for (int k = 0; k < 4; k++) begin
        acc_r = AW'($signed(rd_re[eq][k]));
        acc_i = AW'($signed(rd_im[eq][k]));
        for (int j = 0; j < NENG; j++) begin
          if (mem[j] && (j != int'(eng))) begin
            acc_r -= AW'($signed(sp_re[j][k]));
            acc_i -= AW'($signed(sp_im[j][k]));
          end
        end
        fx_re[eng][k] = acc_r[OW-1:0];
        fx_im[eng][k] = acc_i[OW-1:0];
      end
    end
  end
endmodule

// File: rtl/fft_pair_corrector.sv
module fft_pair_corrector
  import fft_pc_pkg::*;
#(
  parameter int SW = 12,
  localparam int OW = SW + 2,
  localparam int RW = SW + 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [3:0][3:0][SW-1:0] in_re,
  input  logic [3:0][3:0][SW-1:0] in_im,
  input  logic [3:0]              inj_eng,
  input  logic [1:0]              inj_bin,
  input  logic [OW-1:0]           inj_flip,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [3:0][3:0][OW-1:0] out_re,
  output logic [3:0][3:0][OW-1:0] out_im,
  output logic [3:0]              out_fault,
  output logic                    out_uncorr
);
  localparam int PW = SW + 2;

  logic adv;
  logic v1, v2;

  logic [3:0][3:0][OW-1:0]      raw_re, raw_im, hit_re, hit_im;
  logic [3:0]                   bad;
  logic [NRED-1:0][3:0][PW-1:0] psum_re, psum_im;
  logic [NRED-1:0][3:0][RW-1:0] red_re, red_im;

  logic [3:0][3:0][OW-1:0]      s1_re, s1_im, s2_re, s2_im, f1_re, f1_im, f2_re, f2_im;
  logic [NRED-1:0][3:0][RW-1:0] s1_rr, s1_ri, s2_rr, s2_ri;
  logic [3:0]                   s1_flag, s2_flag;
  fix_plan_t                    p1, p2;

  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  // original engines, soft-error injection and detectors
  for (genvar e = 0; e < NENG; e++) begin : g_eng
    fft4_core #(.IW(SW), .OW(OW)) u_fft (
      .xr(in_re[e]), .xi(in_im[e]), .yr(raw_re[e]), .yi(raw_im[e]));

    always_comb begin
      hit_im[e] = raw_im[e];
      for (int k = 0; k < 4; k++)
        hit_re[e][k] = raw_re[e][k] ^ ((inj_eng[e] && (int'(inj_bin) == k)) ? inj_flip : '0);
    end

    sum_checker #(.SW(SW), .OW(OW)) u_chk (
      .xr(in_re[e]), .xi(in_im[e]), .yr(hit_re[e]), .yi(hit_im[e]), .bad(bad[e]));
  end

  // redundant engines on three-input sums
  for (genvar q = 0; q < NRED; q++) begin : g_red
    localparam logic [3:0] MEM = eq_members(2'(q));
    always_comb begin
      for (int n = 0; n < 4; n++) begin
        psum_re[q][n] = '0;
        psum_im[q][n] = '0;
        for (int j = 0; j < NENG; j++) begin
          if (MEM[j]) begin
            psum_re[q][n] = psum_re[q][n] + PW'($signed(in_re[j][n]));
            psum_im[q][n] = psum_im[q][n] + PW'($signed(in_im[j][n]));
          end
        end
      end
    end
    fft4_core #(.IW(PW), .OW(RW)) u_fft (
      .xr(psum_re[q]), .xi(psum_im[q]), .yr(red_re[q]), .yi(red_im[q]));
  end

  // stage 1: raw spectra and flags
  always_ff @(posedge clk) begin
    if (!rst_n) v1 <= 1'b0;
    else if (adv) v1 <= in_valid;
    if (adv) begin
      s1_re <= hit_re;  s1_im <= hit_im;
      s1_rr <= red_re;  s1_ri <= red_im;
      s1_flag <= bad;
    end
  end

  always_comb p1 = plan_for(s1_flag);

  repair_unit #(.OW(OW), .RW(RW)) u_fix1 (
    .en(p1.en1), .eng(p1.eng1), .eq(p1.eq1),
    .sp_re(s1_re), .sp_im(s1_im), .rd_re(s1_rr), .rd_im(s1_ri),
    .fx_re(f1_re), .fx_im(f1_im));

  // stage 2: first engine rebuilt
  always_ff @(posedge clk) begin
    if (!rst_n) v2 <= 1'b0;
    else if (adv) v2 <= v1;
    if (adv) begin
      s2_re <= f1_re;   s2_im <= f1_im;
      s2_rr <= s1_rr;   s2_ri <= s1_ri;
      s2_flag <= s1_flag;
      p2 <= p1;
    end
  end

  repair_unit #(.OW(OW), .RW(RW)) u_fix2 (
    .en(p2.en2), .eng(p2.eng2), .eq(p2.eq2),
    .sp_re(s2_re), .sp_im(s2_im), .rd_re(s2_rr), .rd_im(s2_ri),
    .fx_re(f2_re), .fx_im(f2_im));

  // stage 3: output register
  always_ff @(posedge clk) begin
    if (!rst_n) out_valid <= 1'b0;
    else if (adv) out_valid <= v2;
    if (adv) begin
      out_re <= f2_re;  out_im <= f2_im;
      out_fault  <= s2_flag;
      out_uncorr <= p2.uncorr;
    end
  end

  logic [3:0] m_eq1, m_eq2;
  always_comb begin
    m_eq1 = eq_members(p2.eq1);
    m_eq2 = eq_members(p2.eq2);
  end

  // R6
  first_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    v2 && p2.en2 |-> p2.en1 && !m_eq1[p2.eng2] && m_eq2[p2.eng2] && (p2.eng1 != p2.eng2));
  // R5
  single_plan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    v2 && ($countones(s2_flag) == 1) |-> p2.en1 && !p2.en2 && s2_flag[p2.eng1] && m_eq1[p2.eng1]);
  // R7
  uncorr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_uncorr |-> ($countones(out_fault) >= 3));
  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_re) && $stable(out_im) && $stable(out_fault));
  // R8
  no_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);
endmodule

// File: tb/tb_fft_pair_corrector.sv
`timescale 1ns/1ps
module tb_fft_pair_corrector;
  localparam int SW = 12;
  localparam int OW = SW + 2;

  typedef struct packed {
    logic [15:0]   seed;
    logic [3:0]    eng;
    logic [1:0]    bin;
    logic [OW-1:0] flip;
  } vec_t;

  localparam vec_t TBL [12] = '{
    '{16'd3,   4'b0000, 2'd0, 14'h0000},
    '{16'd41,  4'b0000, 2'd2, 14'h0155},
    '{16'd7,   4'b0001, 2'd0, 14'h0001},
    '{16'd88,  4'b1000, 2'd3, 14'h2000},
    '{16'd12,  4'b0011, 2'd1, 14'h0040},
    '{16'd19,  4'b0101, 2'd2, 14'h0301},
    '{16'd25,  4'b1001, 2'd3, 14'h0008},
    '{16'd33,  4'b0110, 2'd0, 14'h1000},
    '{16'd57,  4'b1010, 2'd1, 14'h0777},
    '{16'd61,  4'b1100, 2'd2, 14'h0002},
    '{16'd70,  4'b0111, 2'd1, 14'h0010},
    '{16'd95,  4'b1111, 2'd3, 14'h0100}
  };

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, out_ready = 1;
  logic in_ready, out_valid, out_uncorr;
  logic [3:0][3:0][SW-1:0] in_re, in_im;
  logic [3:0] inj_eng = '0, out_fault;
  logic [1:0] inj_bin = '0;
  logic [OW-1:0] inj_flip = '0;
  logic [3:0][3:0][OW-1:0] out_re, out_im;

  int n_run = 0, n_fail = 0;
  int exp_re [4][4], exp_im [4][4];

  always #5 clk = ~clk;

  fft_pair_corrector #(.SW(SW)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_re(in_re), .in_im(in_im), .inj_eng(inj_eng), .inj_bin(inj_bin),
    .inj_flip(inj_flip), .out_valid(out_valid), .out_ready(out_ready),
    .out_re(out_re), .out_im(out_im), .out_fault(out_fault), .out_uncorr(out_uncorr));

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int samp(int seed, int e, int n, int im);
    return ((seed * 31 + e * 97 + n * 53 + im * 211) % 3001) - 1500;
  endfunction

  // load inputs and compute expected spectra by the DFT definition
  task automatic load(input int seed, input vec_t v, input bit keep_fault);
    int xr, xi, cr, ci, m;
    logic [OW-1:0] t;
    for (int e = 0; e < 4; e++)
      for (int n = 0; n < 4; n++) begin
        in_re[e][n] = SW'(samp(seed, e, n, 0));
        in_im[e][n] = SW'(samp(seed, e, n, 1));
      end
    for (int e = 0; e < 4; e++)
      for (int k = 0; k < 4; k++) begin
        exp_re[e][k] = 0; exp_im[e][k] = 0;
        for (int n = 0; n < 4; n++) begin
          xr = samp(seed, e, n, 0); xi = samp(seed, e, n, 1);
          m = (k * n) % 4;
          cr = (m == 0) ? 1 : (m == 2) ? -1 : 0;
          ci = (m == 1) ? -1 : (m == 3) ? 1 : 0;
          exp_re[e][k] += xr * cr - xi * ci;
          exp_im[e][k] += xr * ci + xi * cr;
        end
        if (keep_fault && v.eng[e] && (k == int'(v.bin))) begin
          t = OW'(exp_re[e][k]) ^ v.flip;
          exp_re[e][k] = int'($signed(t));
        end
      end
    inj_eng = v.eng; inj_bin = v.bin; inj_flip = v.flip;
  endtask

  task automatic cmp_spec(input string req);
    int bad_n = 0, a = 0, x = 0;
    for (int e = 0; e < 4; e++)
      for (int k = 0; k < 4; k++) begin
        if (int'($signed(out_re[e][k])) != exp_re[e][k] || int'($signed(out_im[e][k])) != exp_im[e][k]) begin
          if (bad_n == 0) begin a = int'($signed(out_re[e][k])); x = exp_re[e][k]; end
          bad_n++;
        end
      end
    check(bad_n == 0, req, "spectra (first bad bin real)", a, x);
  endtask

  task automatic wait_out(output int lat);
    lat = 1;
    while (!out_valid && lat < 12) begin
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int lat, cnt;
    string req;
    vec_t v;
    logic [3:0][3:0][OW-1:0] held;
    load(1, '0, 0);
    repeat (3) @(negedge clk);
    check(out_valid == 0, "R1", "out_valid in reset", out_valid, 0);
    rst_n = 1;
    @(negedge clk);
    check(out_valid == 0, "R1", "out_valid after reset", out_valid, 0);
    check(in_ready == 1, "R1", "in_ready after reset", in_ready, 1);

    // table walk
    foreach (TBL[i]) begin
      v = TBL[i];
      cnt = $countones(v.eng);
      req = (cnt == 0) ? "R2" : (cnt == 1) ? "R5" : (cnt == 2) ? "R6" : "R7";
      load(int'(v.seed), v, cnt >= 3);
      in_valid = 1;
      @(negedge clk);
      in_valid = 0;
      wait_out(lat);
      check(lat == 3, "R3", "latency", lat, 3);
      cmp_spec(req);
      check(out_fault == v.eng, "R4", "fault flags", int'(out_fault), int'(v.eng));
      check(out_uncorr == (cnt >= 3), req, "uncorrectable", out_uncorr, int'(cnt >= 3));
      @(negedge clk);
    end

    // stall with a two-step repair in flight (R8, R6)
    out_ready = 0;
    v = '{16'd140, 4'b0011, 2'd0, 14'h0123};
    load(140, v, 0);
    in_valid = 1;
    @(negedge clk);
    in_valid = 0;
    wait_out(lat);
    check(lat == 3, "R3", "latency into stalled output", lat, 3);
    held = out_re;
    v = '{16'd177, 4'b1100, 2'd1, 14'h0044};
    in_valid = 1;
    inj_eng = v.eng; inj_bin = v.bin; inj_flip = v.flip;
    for (int n = 0; n < 4; n++) begin
      in_re[0][n] = SW'(samp(177, 0, n, 0));
    end
    repeat (4) begin
      @(negedge clk);
      check(out_valid == 1 && out_re == held, "R8", "output held in stall", out_valid, 1);
      check(in_ready == 0, "R8", "in_ready during stall", in_ready, 0);
    end
    cmp_spec("R6");
    check(out_fault == 4'b0011, "R4", "flags in stall", int'(out_fault), 3);
    load(177, v, 0);
    out_ready = 1;
    @(negedge clk);
    in_valid = 0;
    wait_out(lat);
    check(lat == 3, "R8", "stalled offer taken on release", lat, 3);
    cmp_spec("R6");
    check(out_fault == 4'b1100, "R4", "flags after stall", int'(out_fault), 12);
    @(negedge clk);
    check(out_valid == 0, "R8", "single output per accepted vector", out_valid, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule